// File: doc/BRIEF.md
# PCI Outbound Window Translator

This block sits between a processor request bus and the outbound side of a PCI host bridge. Each processor request whose address lies in the fixed 1 GB window from 0x80000000 to 0xBFFFFFFF becomes one outbound PCI cycle descriptor. The descriptor holds a PCI command code, a 32-bit PCI address and the write data. Requests outside the window produce nothing. The low 30 address bits are copied from the processor address. The top two PCI address bits come from a field of a small control register, so software chooses which quarter of PCI memory space the window maps onto.

The same control register sets the cycle type. With its cycle-select bit set, every window access is issued as a configuration read or write rather than a memory read or write. The register also sets the mode of the PCI reset pin: floating as an input, driven low, or driven high. It holds a bus grant policy, an external-access cache disable flag and a fragment-transmit enable, and these are exported to neighbouring logic.

Two state machines do the work. The request machine has the states REQ_IDLE, REQ_MEM and REQ_CFG. From any state it goes to REQ_MEM when a window hit arrives with cycle-select clear, to REQ_CFG when a window hit arrives with cycle-select set, and otherwise to REQ_IDLE. The pin machine has the states PIN_FLOAT, PIN_LOW and PIN_HIGH. On every clock it moves to the state named by the stored reset-mode field, and mode 3 leads to PIN_FLOAT.

Top module: `pci_window_xlat`

## Requirements
- R1: A request with `cpu_valid` high and `cpu_addr[31:30]` equal to 2'b10 makes `req_valid` high for exactly the following cycle. Any other address, or `cpu_valid` low, leaves `req_valid` low in that cycle.
- R2: For an issued request, `req_addr[29:0]` equals the request's `cpu_addr[29:0]` and `req_data` equals its `cpu_wdata`.
- R3: For an issued request, `req_addr[31:30]` equals control-register bits [3:2] as they stood when the request was sampled. The processor address bits [31:30] have no influence on it.
- R4: `req_cmd` is 4'h6 for a memory read and 4'h7 for a memory write when control bit 1 is clear. It is 4'hA for a configuration read and 4'hB for a configuration write when control bit 1 is set.
- R5: Control bits [5:4] set the reset pin. Value 0 gives `prst_oe`=0. Value 1 gives `prst_oe`=1 and `prst_out`=0. Value 2 gives `prst_oe`=1 and `prst_out`=1. The pins follow a register write two clock edges after the write is sampled.
- R6: `grant_mode` shows control bits [7:6] (0 early grant, 1 wait for frame, 2 wait for idle), and the stored value 3 is shown as 0.
- R7: `cache_off` shows control bit 12 and `frag_tx_en` shows control bit 0, one edge after the write.
- R8: A stored reset-mode value of 3 is kept in the register, as read on `ctrl_word`, but drives the pins as mode 0.
- R9: After reset, `ctrl_word` is zero, `req_valid` is low and `prst_oe` is low. Register bits other than 0–7 and 12 always read zero.
- R10: A register write sampled on the same edge as a request does not affect that request. It uses the register value held before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present this cycle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write value |
| req_valid | output | 1 | Outbound cycle descriptor valid |
| req_cmd | output | 4 | PCI command code |
| req_addr | output | 32 | PCI address |
| req_data | output | 32 | Data carried with the cycle |
| prst_oe | output | 1 | Reset pin output enable |
| prst_out | output | 1 | Reset pin driven level |
| grant_mode | output | 2 | Effective grant policy |
| cache_off | output | 1 | External-access cache disable |
| frag_tx_en | output | 1 | Fragment transmit enable |
| ctrl_word | output | 32 | Stored control register contents |

## Verification
The outputs have different latencies. A descriptor appears one edge after its request is sampled. The exported fields and `ctrl_word` change one edge after a register write. The reset pins change two edges after a register write, because the pin machine reads the stored field. The bench drives inputs on the falling edge and keeps a shadow copy of the register. At the next falling edge it compares the descriptor and pins against values computed from the shadow copy held before the edge, and the fields against the copy held after it. This one schedule also covers a write and a request on the same edge.

// File: rtl/pwx_pkg.sv
package pwx_pkg;

    typedef enum logic [1:0] {
        PIN_FLOAT = 2'd0,
        PIN_LOW   = 2'd1,
        PIN_HIGH  = 2'd2
    } pin_state_e;

    typedef enum logic [1:0] {
        REQ_IDLE = 2'd0,
        REQ_MEM  = 2'd1,
        REQ_CFG  = 2'd2
    } req_state_e;

    localparam logic [3:0] CMD_MEM_RD = 4'h6;
    localparam logic [3:0] CMD_MEM_WR = 4'h7;
    localparam logic [3:0] CMD_CFG_RD = 4'hA;
    localparam logic [3:0] CMD_CFG_WR = 4'hB;

    // control register bit positions
    localparam int CB_FRAG    = 0;
    localparam int CB_CFGSEL  = 1;
    localparam int CB_HI_LSB  = 2;
    localparam int CB_RST_LSB = 4;
    localparam int CB_GNT_LSB = 6;
    localparam int CB_NOCACHE = 12;

    localparam logic [31:0] CTRL_MASK = 32'h0000_10FF;

    function automatic pin_state_e pin_from_mode(input logic [1:0] mode);
        pin_state_e s;
        unique case (mode)
            2'd1:    s = PIN_LOW;
            2'd2:    s = PIN_HIGH;
            default: s = PIN_FLOAT;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pwx_ctrl_reg.sv
module pwx_ctrl_reg
    import pwx_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] word,
    output logic             cfg_sel,
    output logic [1:0]       hi_bits,
    output logic [1:0]       rst_mode,
    output logic [1:0]       gnt_eff,
    output logic             nocache,
    output logic             frag
);
    localparam logic [REG_W-1:0] KEEP = REG_W'(CTRL_MASK);

    logic [REG_W-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata & KEEP;
        end
    end

    logic [1:0] gnt_raw;

    always_comb begin
        word     = q;
        cfg_sel  = q[CB_CFGSEL];
        hi_bits  = q[CB_HI_LSB +: 2];
        rst_mode = q[CB_RST_LSB +: 2];
        gnt_raw  = q[CB_GNT_LSB +: 2];
        gnt_eff  = (gnt_raw == 2'd3) ? 2'd0 : gnt_raw;
        nocache  = q[CB_NOCACHE];
        frag     = q[CB_FRAG];
    end
endmodule

// File: rtl/pwx_pin_fsm.sv
module pwx_pin_fsm
    import pwx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    output logic       pin_oe,
    output logic       pin_lvl
);
    pin_state_e state, next;

    always_comb begin
        next = pin_from_mode(mode);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PIN_FLOAT;
        end else begin
            state <= next;
        end
    end

    always_comb begin
        unique case (state)
            PIN_LOW: begin
                pin_oe  = 1'b1;
                pin_lvl = 1'b0;
            end
            PIN_HIGH: begin
                pin_oe  = 1'b1;
                pin_lvl = 1'b1;
            end
            default: begin
                pin_oe  = 1'b0;
                pin_lvl = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pwx_req_fsm.sv
module pwx_req_fsm
    import pwx_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter int          DATA_W  = 32,
    parameter logic [1:0]  WIN_TAG = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              cfg_sel,
    input  logic [1:0]        hi_bits,
    output logic              out_valid,
    output logic [3:0]        out_cmd,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    localparam int LOW_W = ADDR_W - 2;

    req_state_e        state, next;
    logic              hit;
    logic              wr_q;
    logic [LOW_W-1:0]  low_q;
    logic [1:0]        hi_q;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        hit = in_valid && (in_addr[ADDR_W-1 -: 2] == WIN_TAG);
        if (!hit) begin
            next = REQ_IDLE;
        end else if (cfg_sel) begin
            next = REQ_CFG;
        end else begin
            next = REQ_MEM;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= REQ_IDLE;
            wr_q   <= 1'b0;
            low_q  <= '0;
            hi_q   <= '0;
            data_q <= '0;
        end else begin
            state <= next;
            if (hit) begin
                wr_q   <= in_write;
                low_q  <= in_addr[LOW_W-1:0];
                hi_q   <= hi_bits;
                data_q <= in_data;
            end
        end
    end

    always_comb begin
        out_addr = {hi_q, low_q};
        out_data = data_q;
        unique case (state)
            REQ_MEM: begin
                out_valid = 1'b1;
                out_cmd   = wr_q ? CMD_MEM_WR : CMD_MEM_RD;
            end
            REQ_CFG: begin
                out_valid = 1'b1;
                out_cmd   = wr_q ? CMD_CFG_WR : CMD_CFG_RD;
            end
            default: begin
                out_valid = 1'b0;
                out_cmd   = 4'h0;
            end
        endcase
    end
endmodule

// File: rtl/pci_window_xlat.sv
module pci_window_xlat
    import pwx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              ctrl_we,
    input  logic [31:0]       ctrl_wdata,
    output logic              req_valid,
    output logic [3:0]        req_cmd,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              prst_oe,
    output logic              prst_out,
    output logic [1:0]        grant_mode,
    output logic              cache_off,
    output logic              frag_tx_en,
    output logic [31:0]       ctrl_word
);
    logic       cfg_sel;
    logic [1:0] hi_bits;
    logic [1:0] rst_mode;

    pwx_ctrl_reg #(.REG_W(32)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctrl_we),
        .wdata    (ctrl_wdata),
        .word     (ctrl_word),
        .cfg_sel  (cfg_sel),
        .hi_bits  (hi_bits),
        .rst_mode (rst_mode),
        .gnt_eff  (grant_mode),
        .nocache  (cache_off),
        .frag     (frag_tx_en)
    );

    pwx_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_TAG(2'b10)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (cpu_valid),
        .in_write  (cpu_write),
        .in_addr   (cpu_addr),
        .in_data   (cpu_wdata),
        .cfg_sel   (cfg_sel),
        .hi_bits   (hi_bits),
        .out_valid (req_valid),
        .out_cmd   (req_cmd),
        .out_addr  (req_addr),
        .out_data  (req_data)
    );

    pwx_pin_fsm u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (rst_mode),
        .pin_oe  (prst_oe),
        .pin_lvl (prst_out)
    );
endmodule

// File: rtl/pci_window_xlat_chk.sv
module pci_window_xlat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_valid,
    input logic        cpu_write,
    input logic [31:0] cpu_addr,
    input logic [31:0] cpu_wdata,
    input logic        req_valid,
    input logic [3:0]  req_cmd,
    input logic [31:0] req_addr,
    input logic [31:0] req_data,
    input logic        prst_oe,
    input logic        prst_out,
    input logic [1:0]  grant_mode,
    input logic [31:0] ctrl_word
);
    // R1
    window_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($past(cpu_valid) && $past(cpu_addr[31:30]) == 2'b10));

    // R1
    window_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_addr[31:30] == 2'b10) |=> req_valid);

    // R2
    low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[29:0] == $past(cpu_addr[29:0]) && req_data == $past(cpu_wdata)));

    // R3
    hi_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[31:30] == $past(ctrl_word[3:2]));

    // R4
    cmd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_cmd[0] == $past(cpu_write) && req_cmd[3] == $past(ctrl_word[1])));

    // R5
    pin_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prst_out |-> prst_oe);

    // R8
    pin_mode3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_word[5:4]) == 2'd3 |-> !prst_oe);

    // R6
    grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_mode != 2'd3);

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word & ~32'h0000_10FF) == 32'h0);
endmodule

bind pci_window_xlat pci_window_xlat_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_write  (cpu_write),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .req_valid  (req_valid),
    .req_cmd    (req_cmd),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .prst_oe    (prst_oe),
    .prst_out   (prst_out),
    .grant_mode (grant_mode),
    .ctrl_word  (ctrl_word)
);

// File: tb/pci_window_xlat_test.sv
`timescale 1ns/1ps
module pci_window_xlat_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic        cpu_write = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        req_valid;
    logic [3:0]  req_cmd;
    logic [31:0] req_addr;
    logic [31:0] req_data;
    logic        prst_oe;
    logic        prst_out;
    logic [1:0]  grant_mode;
    logic        cache_off;
    logic        frag_tx_en;
    logic [31:0] ctrl_word;

    int checks = 0;
    int errors = 0;
    logic [31:0] model = '0;

    always #2.5 clk = ~clk;

    pci_window_xlat uut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_data(req_data), .prst_oe(prst_oe),
        .prst_out(prst_out), .grant_mode(grant_mode), .cache_off(cache_off),
        .frag_tx_en(frag_tx_en), .ctrl_word(ctrl_word)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] exp_cmd(input logic [31:0] c, input logic wr);
        return c[1] ? (wr ? 4'hB : 4'hA) : (wr ? 4'h7 : 4'h6);
    endfunction

    function automatic logic [1:0] exp_pins(input logic [31:0] c);
        // {oe, level}
        case (c[5:4])
            2'd1:    return 2'b10;
            2'd2:    return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    // One cycle: drive at falling edge, check at the next falling edge.
    task automatic step(input logic v, input logic w, input logic [31:0] a,
                        input logic [31:0] d, input logic we, input logic [31:0] wd);
        logic [31:0] old_c;
        logic        hit;
        logic [1:0]  g;
        cpu_valid = v; cpu_write = w; cpu_addr = a; cpu_wdata = d;
        ctrl_we = we; ctrl_wdata = wd;
        old_c = model;
        hit = v && (a[31:30] == 2'b10);
        @(posedge clk);
        if (we) model = wd & 32'h0000_10FF;
        @(negedge clk);
        // R1 window decode, R10 old register used
        check("R1 req_valid", {31'd0, req_valid}, {31'd0, hit});
        if (hit) begin
            check("R2 low addr", {2'b0, req_addr[29:0]}, {2'b0, a[29:0]});
            check("R2 data", req_data, d);
            check("R3 R10 hi addr", {30'd0, req_addr[31:30]}, {30'd0, old_c[3:2]});
            check("R4 cmd", {28'd0, req_cmd}, {28'd0, exp_cmd(old_c, w)});
        end
        // R5 R8 pins follow the register value held before this edge
        check("R5 R8 pins", {30'd0, prst_oe, prst_out}, {30'd0, exp_pins(old_c)});
        g = (model[7:6] == 2'd3) ? 2'd0 : model[7:6];
        check("R6 grant", {30'd0, grant_mode}, {30'd0, g});
        check("R7 flags", {30'd0, cache_off, frag_tx_en}, {30'd0, model[12], model[0]});
        check("R9 R8 ctrl_word", ctrl_word, model);
        cpu_valid = 1'b0; ctrl_we = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset ctrl_word", ctrl_word, 32'h0);
        check("R9 reset req_valid", {31'd0, req_valid}, 32'h0);
        check("R9 reset pin oe", {31'd0, prst_oe}, 32'h0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 32'h0);
        // R1 boundaries, memory cycles, upper bits 0
        step(1'b1, 1'b0, 32'h7FFF_FFFF, 32'h1, 1'b0, 32'h0);
        step(1'b1, 1'b1, 32'h8000_0000, 32'h2, 1'b0, 32'h0);
        step(1'b1, 1'b0, 32'hBFFF_FFFC, 32'h3, 1'b0, 32'h0);
        step(1'b1, 1'b1, 32'hC000_0000, 32'h4, 1'b0, 32'h0);
        step(1'b1, 1'b1, 32'h0000_1000, 32'h5, 1'b0, 32'h0);
        // R3 R4 configuration with upper bits 3, reserved bits written high (R9)
        step(1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 32'hFFFF_EF0E);
        step(1'b1, 1'b0, 32'h8001_2340, 32'h6, 1'b0, 32'h0);
        step(1'b1, 1'b1, 32'hA000_0010, 32'hDEAD_BEEF, 1'b0, 32'h0);
        // R5 drive low, then high, then reserved mode 3 (R8), grant 3 (R6)
        step(1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 32'h0000_0010);
        step(1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 32'h0);
        step(1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 32'h0000_1021);
        step(1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 32'h0);
        step(1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 32'h0000_00F0);
        step(1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 32'h0);
        // R10 write on the same edge as a request
        step(1'b1, 1'b1, 32'h9000_0000, 32'h77, 1'b1, 32'h0000_000E);
        step(1'b1, 1'b1, 32'h9000_0004, 32'h78, 1'b1, 32'h0000_0000);
        step(1'b1, 1'b0, 32'h9000_0008, 32'h79, 1'b0, 32'h0);
        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            a = $urandom;
            if ($urandom_range(0, 2) != 0) a[31:30] = 2'b10;
            step($urandom_range(0, 3) != 0, 1'($urandom), a, $urandom,
                 $urandom_range(0, 4) == 0, $urandom);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule